// File: doc/BRIEF.md
# Translation Lookaside Buffer with Maintenance Invalidation

This block is a small fully associative translation cache. Each entry holds a 20-bit virtual page number, an 8-bit address space identifier, a global flag, a lock flag and a physical page number. A combinational lookup port returns hit and physical page for a page number and the current identifier. A fill port writes new entries. A maintenance port removes entries in one of four ways:

- every unlocked entry;
- by page plus identifier;
- by identifier alone;
- by page whatever the identifier.

The `SPLIT` parameter selects the organisation. With `SPLIT=1` there are two banks, one for instructions and one for data. With `SPLIT=0` there is a single unified bank. Maintenance requests carry a target code, and the block routes each request to the bank or banks it applies to.

The fill port follows valid/ready rules. A fill is taken on a rising edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is low only when the addressed bank is full and every entry in it is locked. While it is low, a fill that is held is simply not taken and has no effect. The fill may then stay asserted until ready returns. Lookup and maintenance are plain control pins and have no handshake.

Top module: `tlb_mmu_top`

## Requirements
- R1: A lookup hits when some entry is valid, its page number equals `lk_vpn`, and the entry is either global or its identifier equals `lk_asid`. `lk_ppn` gives that entry's physical page, and the lowest-indexed match wins. Both outputs are combinational from the current contents.
- R2: An accepted fill writes the lowest-indexed invalid entry of its bank. The entry is visible to lookups after that clock edge.
- R3: When every entry of the bank is valid, a fill replaces a round-robin victim. The victim is the first unlocked entry at or after a pointer, and the pointer then moves to the entry after the victim. When every entry is valid and locked, `fill_ready` is 0 and a held fill changes nothing.
- R4: Operation code 0 invalidates every unlocked entry and keeps locked ones. The 32-bit operand is ignored.
- R5: Operation code 1 takes the page from operand bits 31:12 and the identifier from bits 7:0. Bits 11:8 are ignored. It removes entries whose page matches and that are either global or carry that identifier.
- R6: Operation code 2 removes non-global entries whose identifier equals operand bits 7:0. Bits 31:8 are ignored.
- R7: Operation code 3 removes every entry whose page equals operand bits 31:12, whatever its identifier or global flag.
- R8: With `SPLIT=1`, target 1 acts on the instruction bank only and target 2 acts on the data bank only. Targets 0 and 3 act on both banks. `lk_side` and `fill_side` equal to 0 select the instruction bank, and 1 selects the data bank.
- R9: With `SPLIT=0`, every target acts on the single bank, and `lk_side` and `fill_side` have no effect.
- R10: A maintenance request takes effect on the clock edge where `mnt_valid` is high. A lookup in that same cycle still sees the contents from before the invalidation. The lock flag protects entries only against operation code 0; operation codes 1 to 3 remove locked entries as well.
- R11: After reset, every entry is invalid, the victim pointer is 0, no lookup hits and `fill_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_side | input | 1 | Lookup bank select: 0 instruction, 1 data |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Current address space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hitting entry |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill can be accepted by the selected bank |
| fill_side | input | 1 | Fill bank select: 0 instruction, 1 data |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_asid | input | 8 | Fill identifier |
| fill_global | input | 1 | Fill global flag |
| fill_lock | input | 1 | Fill lock flag |
| fill_ppn | input | PPN_W | Fill physical page |
| mnt_valid | input | 1 | Maintenance request strobe |
| mnt_op | input | 2 | Operation code: 0 all, 1 page+id, 2 id, 3 page any id |
| mnt_target | input | 2 | Target: 0 unified, 1 instruction, 2 data, 3 unified |
| mnt_operand | input | 32 | Maintenance operand |

## Verification
Lookup results are combinational. The bench therefore samples them one time step after it drives the lookup inputs on a falling edge. Fills and maintenance requests are driven on a falling edge and captured on the next rising edge, so their effect is checked at the falling edge that follows. In that same window the bench checks `fill_ready`, which follows the state combinationally. For the same-cycle rule of R10, a lookup is sampled while the request is still on the pins and before the capturing edge, where it must still show the old contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int OPND_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int ID_W     = 8;
  localparam int VPN_W    = OPND_W - PAGE_LSB;

  typedef enum logic [1:0] {
    OP_ALL     = 2'd0,
    OP_VA_ID   = 2'd1,
    OP_ID      = 2'd2,
    OP_VA_ANY  = 2'd3
  } inv_op_e;

  typedef enum logic [1:0] {
    TGT_UNI    = 2'd0,
    TGT_INSTR  = 2'd1,
    TGT_DATA   = 2'd2,
    TGT_UNI_B  = 2'd3
  } inv_tgt_e;

  typedef struct packed {
    inv_op_e          op;
    logic [VPN_W-1:0] vpn;
    logic [ID_W-1:0]  asid;
  } inv_req_t;
endpackage

// File: rtl/tlb_inv_route.sv
module tlb_inv_route
  import tlb_pkg::*;
#(
  parameter int SPLIT = 1,
  localparam int NB   = (SPLIT != 0) ? 2 : 1
) (
  input  logic              mnt_valid,
  input  logic [1:0]        mnt_op,
  input  logic [1:0]        mnt_target,
  input  logic [OPND_W-1:0] mnt_operand,
  output inv_req_t          req,
  output logic [NB-1:0]     bank_en
);
  inv_tgt_e tgt;
  assign tgt      = inv_tgt_e'(mnt_target);
  assign req.op   = inv_op_e'(mnt_op);
  assign req.vpn  = mnt_operand[OPND_W-1:PAGE_LSB];
  assign req.asid = mnt_operand[ID_W-1:0];

  generate
    if (SPLIT != 0) begin : g_split
      // bank 0 = instruction, bank 1 = data
      assign bank_en[0] = mnt_valid && (tgt != TGT_DATA);
      assign bank_en[1] = mnt_valid && (tgt != TGT_INSTR);
    end else begin : g_uni
      assign bank_en[0] = mnt_valid;
    end
  endgenerate
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] locked,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   slot,
  output logic               slot_ok,
  output logic               from_rr
);
  int idx;
  always_comb begin
    slot    = '0;
    slot_ok = 1'b0;
    from_rr = 1'b0;
    idx     = 0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        slot    = IDX_W'(i);
        slot_ok = 1'b1;
      end
    end
    if (!slot_ok) begin
      for (int k = ENTRIES - 1; k >= 0; k--) begin
        idx = int'(rr_ptr) + k;
        if (idx >= ENTRIES) idx = idx - ENTRIES;
        if (!locked[idx]) begin
          slot    = IDX_W'(idx);
          slot_ok = 1'b1;
          from_rr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ID_W-1:0]  lk_asid,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ID_W-1:0]  fill_asid,
  input  logic             fill_global,
  input  logic             fill_lock,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_en,
  input  inv_req_t         inv_req
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, lock_q, glob_q, kill, valid_nxt;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ID_W-1:0]    asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q, slot;
  logic               slot_ok, from_rr, fill_fire;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid   (valid_q),
    .locked  (lock_q),
    .rr_ptr  (rr_q),
    .slot    (slot),
    .slot_ok (slot_ok),
    .from_rr (from_rr)
  );

  assign fill_ready = slot_ok;
  assign fill_fire  = fill_en && slot_ok;

  // lookup: lowest index wins
  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && vpn_q[i] == lk_vpn &&
          (glob_q[i] || asid_q[i] == lk_asid)) begin
        lk_hit = 1'b1;
        lk_ppn = ppn_q[i];
      end
    end
  end

  // invalidation selection
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      unique case (inv_req.op)
        OP_ALL:    kill[i] = !lock_q[i];
        OP_VA_ID:  kill[i] = (vpn_q[i] == inv_req.vpn) &&
                             (glob_q[i] || asid_q[i] == inv_req.asid);
        OP_ID:     kill[i] = !glob_q[i] && asid_q[i] == inv_req.asid;
        OP_VA_ANY: kill[i] = (vpn_q[i] == inv_req.vpn);
        default:   kill[i] = 1'b0;
      endcase
      kill[i] = kill[i] && valid_q[i] && inv_en;
    end
  end

  always_comb begin
    valid_nxt = valid_q & ~kill;
    if (fill_fire) valid_nxt[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      glob_q  <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_nxt;
      if (fill_fire) begin
        lock_q[slot] <= fill_lock;
        glob_q[slot] <= fill_global;
        if (from_rr)
          rr_q <= (int'(slot) == ENTRIES - 1) ? '0 : slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      vpn_q[slot]  <= fill_vpn;
      asid_q[slot] <= fill_asid;
      ppn_q[slot]  <= fill_ppn;
    end
  end

  // R11
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));
  // R1
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |-> !lk_hit);
  // R2
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !inv_en) |=> valid_q[$past(slot)]);
  // R3
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ready |-> ((&valid_q) && (&lock_q)));
  // R4
  inv_all_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_req.op == OP_ALL && !fill_fire) |=>
      (valid_q == $past(valid_q & lock_q)));
  // R10
  inv_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_fire) |=>
      ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

// File: rtl/tlb_mmu_top.sv
module tlb_mmu_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PPN_W   = 20,
  parameter int SPLIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_side,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ID_W-1:0]   lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic              fill_side,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ID_W-1:0]   fill_asid,
  input  logic              fill_global,
  input  logic              fill_lock,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              mnt_valid,
  input  logic [1:0]        mnt_op,
  input  logic [1:0]        mnt_target,
  input  logic [OPND_W-1:0] mnt_operand
);
  localparam int NB = (SPLIT != 0) ? 2 : 1;

  inv_req_t         req;
  logic [NB-1:0]    bank_en, hit_b, rdy_b, fill_b;
  logic [PPN_W-1:0] ppn_b [NB];

  tlb_inv_route #(.SPLIT(SPLIT)) u_route (
    .mnt_valid   (mnt_valid),
    .mnt_op      (mnt_op),
    .mnt_target  (mnt_target),
    .mnt_operand (mnt_operand),
    .req         (req),
    .bank_en     (bank_en)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      if (NB == 1) begin : g_one
        assign fill_b[b] = fill_valid;
      end else begin : g_sel
        assign fill_b[b] = fill_valid && (fill_side == b[0]);
      end
      tlb_bank #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_vpn      (lk_vpn),
        .lk_asid     (lk_asid),
        .lk_hit      (hit_b[b]),
        .lk_ppn      (ppn_b[b]),
        .fill_en     (fill_b[b]),
        .fill_ready  (rdy_b[b]),
        .fill_vpn    (fill_vpn),
        .fill_asid   (fill_asid),
        .fill_global (fill_global),
        .fill_lock   (fill_lock),
        .fill_ppn    (fill_ppn),
        .inv_en      (bank_en[b]),
        .inv_req     (req)
      );
    end

    if (NB == 1) begin : g_out_uni
      assign lk_hit     = hit_b[0];
      assign lk_ppn     = ppn_b[0];
      assign fill_ready = rdy_b[0];
    end else begin : g_out_split
      assign lk_hit     = lk_side ? hit_b[1] : hit_b[0];
      assign lk_ppn     = lk_side ? ppn_b[1] : ppn_b[0];
      assign fill_ready = fill_side ? rdy_b[1] : rdy_b[0];
    end
  endgenerate

  // R8
  route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mnt_valid |-> (bank_en == '0));
endmodule

// File: tb/test_tlb_mmu_top.sv
`timescale 1ns/100ps
module test_tlb_mmu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        lk_side = 0, fill_side = 0, fill_global = 0, fill_lock = 0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_ppn = '0;
  logic [7:0]  lk_asid = '0, fill_asid = '0;
  logic        s_fv = 0, u_fv = 0, s_mv = 0, u_mv = 0;
  logic [1:0]  mnt_op = '0, mnt_target = '0;
  logic [31:0] mnt_operand = '0;
  logic        s_hit, u_hit, s_rdy, u_rdy;
  logic [19:0] s_ppn, u_ppn;
  bit          use_u = 0;

  int total = 0, bad = 0;

  tlb_mmu_top #(.ENTRIES(4), .PPN_W(20), .SPLIT(1)) i_tlb_mmu_top (
    .clk(clk), .rst_n(rst_n), .lk_side(lk_side), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(s_hit), .lk_ppn(s_ppn), .fill_valid(s_fv), .fill_ready(s_rdy),
    .fill_side(fill_side), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_global(fill_global), .fill_lock(fill_lock), .fill_ppn(fill_ppn),
    .mnt_valid(s_mv), .mnt_op(mnt_op), .mnt_target(mnt_target), .mnt_operand(mnt_operand));

  tlb_mmu_top #(.ENTRIES(4), .PPN_W(20), .SPLIT(0)) i_tlb_mmu_top_uni (
    .clk(clk), .rst_n(rst_n), .lk_side(lk_side), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(u_hit), .lk_ppn(u_ppn), .fill_valid(u_fv), .fill_ready(u_rdy),
    .fill_side(fill_side), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_global(fill_global), .fill_lock(fill_lock), .fill_ppn(fill_ppn),
    .mnt_valid(u_mv), .mnt_op(mnt_op), .mnt_target(mnt_target), .mnt_operand(mnt_operand));

  typedef struct packed {
    logic        side;
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        hit;
    logic [19:0] ppn;
  } lvec_t;

  // R1 / R8 lookup table against the first fill pattern
  localparam lvec_t LV [8] = '{
    '{1'b1, 20'h00010, 8'd5, 1'b1, 20'hA0000},
    '{1'b1, 20'h00010, 8'd6, 1'b1, 20'hA0003},
    '{1'b1, 20'h00010, 8'd7, 1'b0, 20'h00000},
    '{1'b1, 20'h00020, 8'd3, 1'b1, 20'hA0001},
    '{1'b1, 20'h00030, 8'd7, 1'b1, 20'hA0002},
    '{1'b1, 20'h00030, 8'd8, 1'b0, 20'h00000},
    '{1'b0, 20'h00010, 8'd5, 1'b1, 20'hB0000},
    '{1'b0, 20'h00020, 8'd9, 1'b0, 20'h00000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input bit u, input bit sd, input logic [19:0] v, input logic [7:0] a,
                         input bit g, input bit l, input logic [19:0] p);
    @(negedge clk);
    fill_side = sd; fill_vpn = v; fill_asid = a; fill_global = g; fill_lock = l; fill_ppn = p;
    if (u) u_fv = 1'b1; else s_fv = 1'b1;
    @(negedge clk);
    u_fv = 1'b0; s_fv = 1'b0;
  endtask

  task automatic do_mnt(input bit u, input logic [1:0] tgt, input logic [1:0] op, input logic [31:0] opnd);
    @(negedge clk);
    mnt_target = tgt; mnt_op = op; mnt_operand = opnd;
    if (u) u_mv = 1'b1; else s_mv = 1'b1;
    @(negedge clk);
    u_mv = 1'b0; s_mv = 1'b0;
  endtask

  task automatic look(input bit u, input bit sd, input logic [19:0] v, input logic [7:0] a,
                      input bit eh, input logic [19:0] ep, input string tag);
    logic h;
    logic [19:0] p;
    lk_side = sd; lk_vpn = v; lk_asid = a;
    #1;
    h = u ? u_hit : s_hit;
    p = u ? u_ppn : s_ppn;
    check(h == eh, tag, {31'd0, h}, {31'd0, eh});
    if (eh) check(p == ep, tag, {12'd0, p}, {12'd0, ep});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    look(0, 1, 20'h00010, 8'd5, 0, '0, "R11 empty data bank");
    look(1, 0, 20'h00010, 8'd5, 0, '0, "R11 empty unified bank");
    fill_side = 1; #1;
    check(s_rdy == 1'b1, "R11 ready after reset", {31'd0, s_rdy}, 32'd1);

    // R2 fills land in lowest invalid slot
    do_fill(0, 1, 20'h00010, 8'd5, 0, 0, 20'hA0000);
    do_fill(0, 1, 20'h00020, 8'd9, 1, 0, 20'hA0001);
    do_fill(0, 1, 20'h00030, 8'd7, 0, 1, 20'hA0002);
    do_fill(0, 1, 20'h00010, 8'd6, 0, 0, 20'hA0003);
    do_fill(0, 0, 20'h00010, 8'd5, 0, 0, 20'hB0000);
    foreach (LV[i]) look(0, LV[i].side, LV[i].vpn, LV[i].asid, LV[i].hit, LV[i].ppn, "R1 table");

    // R3 round robin with lock skip
    fill_side = 1; #1;
    check(s_rdy == 1'b1, "R3 full but unlocked ready", {31'd0, s_rdy}, 32'd1);
    do_fill(0, 1, 20'h00040, 8'd1, 0, 0, 20'hC0000);
    look(0, 1, 20'h00010, 8'd5, 0, '0, "R3 victim 0 replaced");
    look(0, 1, 20'h00040, 8'd1, 1, 20'hC0000, "R3 new entry");
    do_fill(0, 1, 20'h00050, 8'd1, 0, 0, 20'hC0001);
    do_fill(0, 1, 20'h00060, 8'd1, 0, 0, 20'hC0002);
    look(0, 1, 20'h00030, 8'd7, 1, 20'hA0002, "R3 locked skipped");
    look(0, 1, 20'h00010, 8'd6, 0, '0, "R3 victim 3 replaced");
    look(0, 1, 20'h00060, 8'd1, 1, 20'hC0002, "R3 third victim");

    // R10 same cycle lookup sees old contents, R5 op 1 with bits 11:8 set
    @(negedge clk);
    mnt_target = 2'd2; mnt_op = 2'd1; mnt_operand = {20'h00050, 4'hF, 8'h01}; s_mv = 1'b1;
    look(0, 1, 20'h00050, 8'd1, 1, 20'hC0001, "R10 pre-invalidate view");
    @(negedge clk);
    s_mv = 1'b0;
    look(0, 1, 20'h00050, 8'd1, 0, '0, "R5 page+id removed");
    look(0, 1, 20'h00040, 8'd1, 1, 20'hC0000, "R5 other page kept");

    // R6 identifier only, upper operand bits garbage
    do_mnt(0, 2'd2, 2'd2, 32'hFFFFFF01);
    look(0, 1, 20'h00040, 8'd1, 0, '0, "R6 id match removed");
    look(0, 1, 20'h00060, 8'd1, 0, '0, "R6 id match removed 2");
    look(0, 1, 20'h00030, 8'd7, 1, 20'hA0002, "R6 other id kept");

    // R5 global entry removed regardless of id
    do_fill(0, 1, 20'h00070, 8'd2, 1, 0, 20'hD0000);
    look(0, 1, 20'h00070, 8'd9, 1, 20'hD0000, "R1 global hit any id");
    do_mnt(0, 2'd2, 2'd1, {20'h00070, 4'h0, 8'h03});
    look(0, 1, 20'h00070, 8'd2, 0, '0, "R5 global removed");

    // R7 page across identifiers
    do_fill(0, 1, 20'h00080, 8'd2, 0, 0, 20'hD0001);
    do_fill(0, 1, 20'h00080, 8'd3, 0, 0, 20'hD0002);
    do_mnt(0, 2'd2, 2'd3, {20'h00080, 4'h0, 8'h44});
    look(0, 1, 20'h00080, 8'd2, 0, '0, "R7 id 2 removed");
    look(0, 1, 20'h00080, 8'd3, 0, '0, "R7 id 3 removed");

    // R4 + R8 unified target to split banks
    do_fill(0, 1, 20'h00090, 8'd2, 0, 0, 20'hD0003);
    do_mnt(0, 2'd0, 2'd0, 32'hDEADBEEF);
    look(0, 1, 20'h00090, 8'd2, 0, '0, "R4 unlocked removed");
    look(0, 1, 20'h00030, 8'd7, 1, 20'hA0002, "R4 locked kept");
    look(0, 0, 20'h00010, 8'd5, 0, '0, "R8 unified hits instr bank");

    // R8 single-bank targets
    do_fill(0, 0, 20'h000A0, 8'd1, 0, 0, 20'hE0000);
    do_fill(0, 1, 20'h000A0, 8'd1, 0, 0, 20'hE0001);
    do_mnt(0, 2'd1, 2'd0, 32'h0);
    look(0, 0, 20'h000A0, 8'd1, 0, '0, "R8 instr target clears instr");
    look(0, 1, 20'h000A0, 8'd1, 1, 20'hE0001, "R8 instr target spares data");
    do_mnt(0, 2'd2, 2'd0, 32'h0);
    look(0, 1, 20'h000A0, 8'd1, 0, '0, "R8 data target clears data");

    // R3 all locked: back-pressure, ignored fill; R10 targeted ops remove locked
    do_fill(0, 1, 20'h000B0, 8'd4, 0, 1, 20'h000F0);
    do_fill(0, 1, 20'h000B1, 8'd4, 0, 1, 20'h000F1);
    do_fill(0, 1, 20'h000B2, 8'd4, 0, 1, 20'h000F2);
    fill_side = 1; #1;
    check(s_rdy == 1'b0, "R3 all locked not ready", {31'd0, s_rdy}, 32'd0);
    do_fill(0, 1, 20'h000C0, 8'd4, 0, 0, 20'h00123);
    look(0, 1, 20'h000C0, 8'd4, 0, '0, "R3 held fill ignored");
    look(0, 1, 20'h000B0, 8'd4, 1, 20'h000F0, "R3 locked entry intact");
    do_mnt(0, 2'd2, 2'd0, 32'h0);
    look(0, 1, 20'h000B1, 8'd4, 1, 20'h000F1, "R4 all locked survive");
    do_mnt(0, 2'd2, 2'd3, {20'h000B1, 12'h000});
    look(0, 1, 20'h000B1, 8'd4, 0, '0, "R10 page op removes locked");
    fill_side = 1; #1;
    check(s_rdy == 1'b1, "R3 ready returns", {31'd0, s_rdy}, 32'd1);

    // R9 unified configuration ignores sides
    do_fill(1, 0, 20'h00011, 8'd1, 0, 0, 20'hF0000);
    look(1, 1, 20'h00011, 8'd1, 1, 20'hF0000, "R9 side ignored on lookup");
    do_mnt(1, 2'd1, 2'd1, {20'h00011, 4'h0, 8'h01});
    look(1, 0, 20'h00011, 8'd1, 0, '0, "R9 instr target acts on unified");
    do_fill(1, 1, 20'h00012, 8'd1, 0, 0, 20'hF0001);
    look(1, 0, 20'h00012, 8'd1, 1, 20'hF0001, "R9 data fill seen on instr side");
    do_mnt(1, 2'd2, 2'd2, 32'h00000001);
    look(1, 1, 20'h00012, 8'd1, 0, '0, "R9 data target acts on unified");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule